// File: doc/BRIEF.md
# Synchronous Burst Read Sequencer

This block is the device-side read path of a memory that delivers data in synchronous bursts. A host pulls chip enable low and pulses the active-low address strobe with a word address on the address bus. The block samples that address on a clock edge and counts a programmable number of clocks. From then on it puts one data word on the output bus every clock. The word addresses walk upward inside an aligned group of four and wrap back to the start of the group. A one-clock, active-low indicator marks either the final word of the group or the word before it. This lets the host plan when to end or re-issue the burst.

The stored data comes from a small synchronous read memory inside the block. Its content is computed from the address, so every word is known without a load path. A 4-bit latency code and one indicator-select bit come in as configuration. Output enable gates only the data bus; it does not stop the burst. Chip enable aborts the burst. A fresh strobe edge restarts the burst from a new address at any time.

Top module: `burst_read_seq`

## Requirements
- R1: While reset is held, and in the cycle after it ends, `dataValid` is 0, `dataOut` is 0 and `indN` is 1, even with `ceN` and `oeN` low.
- R2: A burst starts, and `addr` is captured, at a rising clock edge where `ceN` is 0, `advN` is 0, and `advN` was 1 at the previous edge. Holding `advN` low for further edges does not restart the burst. A strobe that is already low when `ceN` falls starts nothing.
- R3: Let the start edge be t0, and let L be the clock count decoded from `latCode`. The first word is visible in the cycle after edge t0+L, and no word is visible before it. Codes 1 to 7 decode to code+2 clocks (3 to 9).
- R4: Latency codes 0 and 8 to 15 behave exactly like code 1, which is 3 clocks.
- R5: Word k of the burst (k = 0, 1, …) is visible in the cycle after edge t0+L+k. Its address keeps the upper six bits of the captured address, and its low two bits are (captured low bits + k) mod 4. The burst runs on for as long as `ceN` stays low.
- R6: The value of the word at 8-bit address a is (a × 32'h01010101) XOR 32'hC35AC35A.
- R7: `indN` is 0 for exactly the one cycle in which the word with low address bits 3 is due, when `indEarly` = 0. When `indEarly` = 1, it is 0 in the cycle of the word with low bits 2. At all other times it is 1.
- R8: While `oeN` is 1, `dataValid` and `dataOut` are 0 in the same cycle. The burst keeps advancing, and `indN` still pulses. After `oeN` returns low, the word due in that cycle is shown.
- R9: While `ceN` is 1, `dataValid` is 0 and `indN` is 1 in the same cycle. A `ceN` high at a clock edge aborts the burst, so no word appears after `ceN` returns low until a new strobe arrives.
- R10: A new strobe edge during the wait or the data phase discards the current burst. It restarts with the new address and a fresh latency count, and no word of the old burst appears after the restart edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| ceN | input | 1 | Chip enable, active low |
| oeN | input | 1 | Output enable, active low |
| advN | input | 1 | Address strobe, active low |
| addr | input | 8 | Word address, sampled at burst start |
| latCode | input | 4 | Initial latency code |
| indEarly | input | 1 | Indicator position: 0 on the last word of the group, 1 on the word before it |
| dataOut | output | 32 | Burst data word, zero when not valid |
| dataValid | output | 1 | High when `dataOut` carries a burst word |
| indN | output | 1 | Active-low end-of-group indicator |

## Verification
The data word and `indN` are due in the cycle after edge t0+L+k, while the `oeN` and `ceN` gating acts in the same cycle the enable changes. The bench drives every input just after a falling edge and reads every output at the next falling edge, so each read reflects exactly the rising edge between them. Each expected value comes from the number of rising edges since the start edge: the bench decodes L from the latency code and derives the word index, the wrapped address and the indicator position from that count. A sweep covers all 16 latency codes, both indicator positions and all four starting offsets, and directed runs add held strobes, enable toggles and restarts in both the wait and the data phase.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

  localparam int LAT_CODE_W = 4;
  localparam int LAT_W      = 4;

  typedef enum logic [1:0] {
    S_IDLE   = 2'd0,
    S_WAIT   = 2'd1,
    S_STREAM = 2'd2
  } seqState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic loadAddr;
    logic readEn;
  } seqStrobes_t;

  // codes 1..7 give code+2 clocks, everything else falls back to 3
  function automatic logic [LAT_W-1:0] decodeLatency(input logic [LAT_CODE_W-1:0] code);
    if (code >= 4'd1 && code <= 4'd7) begin
      return code + 4'd2;
    end
    return 4'd3;
  endfunction

endpackage

// File: rtl/burst_ctrl.sv
module burst_ctrl
  import burst_seq_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  ceN,
  input  logic                  advN,
  input  logic [LAT_CODE_W-1:0] latCode,
  output seqStrobes_t           strobes
);

  seqState_e        state;
  logic [LAT_W-1:0] waitCnt;
  logic [LAT_W-1:0] latNow;
  logic             advPrev;
  logic             startNow;

  assign latNow   = decodeLatency(latCode);
  // first edge with the strobe low after it was seen high
  assign startNow = !ceN && !advN && advPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= S_IDLE;
      waitCnt <= '0;
      advPrev <= 1'b1;
    end else begin
      advPrev <= advN;
      if (startNow) begin
        state   <= S_WAIT;
        waitCnt <= latNow - LAT_W'(1);
      end else if (ceN) begin
        state   <= S_IDLE;
      end else begin
        unique case (state)
          S_WAIT: begin
            if (waitCnt == LAT_W'(1)) begin
              state <= S_STREAM;
            end else begin
              waitCnt <= waitCnt - LAT_W'(1);
            end
          end
          S_STREAM: state <= S_STREAM;
          default:  state <= S_IDLE;
        endcase
      end
    end
  end

  always_comb begin
    strobes.loadAddr = startNow;
    strobes.readEn   = (state == S_STREAM) && !ceN && !startNow;
  end

  // ---- checking aids: independent edge count since the last start ----
  logic [LAT_W:0]   chkElapsed;
  logic [LAT_W-1:0] chkLat;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      chkElapsed <= '0;
      chkLat     <= 4'd3;
    end else if (startNow) begin
      chkElapsed <= '0;
      chkLat     <= latNow;
    end else if (chkElapsed != '1) begin
      chkElapsed <= chkElapsed + 1'b1;
    end
  end

  // R2: a start edge always enters the wait phase
  p_start_wait_r2: assert property (@(posedge clk) disable iff (!rstN)
    startNow |=> (state == S_WAIT));

  // R3: no read is issued while waiting
  p_wait_quiet_r3: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_WAIT) |-> !strobes.readEn);

  // R3: the data phase opens L-1 edges after the start edge
  p_latency_r3: assert property (@(posedge clk) disable iff (!rstN)
    ((state == S_STREAM) && ($past(state) == S_WAIT))
      |-> (chkElapsed == ({1'b0, chkLat} - 1'b1)));

endmodule

// File: rtl/burst_rom.sv
module burst_rom #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData
);

  localparam int LANES = DATA_W / 8;
  localparam logic [DATA_W-1:0] SPREAD = {LANES{8'h01}};
  localparam logic [DATA_W-1:0] SALT   = {(DATA_W / 16){16'hC35A}};

  // content is a pure function of the address, no storage needed
  function automatic logic [DATA_W-1:0] contentAt(input logic [ADDR_W-1:0] a);
    return (DATA_W'(a) * SPREAD) ^ SALT;
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdData <= '0;
    end else if (rdEn) begin
      rdData <= contentAt(rdAddr);
    end
  end

endmodule

// File: rtl/burst_datapath.sv
module burst_datapath
  import burst_seq_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int WRAP_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobes_t       strobes,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic              indEarly,
  output logic              wordValid,
  output logic [DATA_W-1:0] wordData,
  output logic              indHit
);

  localparam int UPPER_W = ADDR_W - WRAP_W;
  localparam logic [WRAP_W-1:0] OFF_LAST   = '1;
  localparam logic [WRAP_W-1:0] OFF_PENULT = OFF_LAST - WRAP_W'(1);

  logic [UPPER_W-1:0] upperAddr;
  logic [WRAP_W-1:0]  offset;
  logic [WRAP_W-1:0]  indTarget;

  assign indTarget = indEarly ? OFF_PENULT : OFF_LAST;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      upperAddr <= '0;
      offset    <= '0;
      wordValid <= 1'b0;
      indHit    <= 1'b0;
    end else begin
      wordValid <= strobes.readEn;
      indHit    <= strobes.readEn && (offset == indTarget);
      if (strobes.loadAddr) begin
        upperAddr <= addrIn[ADDR_W-1:WRAP_W];
        offset    <= addrIn[WRAP_W-1:0];
      end else if (strobes.readEn) begin
        offset    <= offset + WRAP_W'(1);
      end
    end
  end

  burst_rom #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) u_rom (
    .clk    (clk),
    .rstN   (rstN),
    .rdEn   (strobes.readEn),
    .rdAddr ({upperAddr, offset}),
    .rdData (wordData)
  );

  // R5: consecutive reads step the wrapped offset by one
  p_offset_step_r5: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.readEn && $past(strobes.readEn) && !$past(strobes.loadAddr))
      |-> (offset == WRAP_W'($past(offset) + WRAP_W'(1))));

  // R5: the upper address moves only on a load
  p_upper_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    !$past(strobes.loadAddr) |-> $stable(upperAddr));

  // R7: the indicator never lasts two cycles
  p_ind_pulse_r7: assert property (@(posedge clk) disable iff (!rstN)
    indHit |=> !indHit);

endmodule

// File: rtl/burst_read_seq.sv
module burst_read_seq
  import burst_seq_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int WRAP_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ceN,
  input  logic              oeN,
  input  logic              advN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [3:0]        latCode,
  input  logic              indEarly,
  output logic [DATA_W-1:0] dataOut,
  output logic              dataValid,
  output logic              indN
);

  seqStrobes_t       strobes;
  logic              wordValid;
  logic [DATA_W-1:0] wordData;
  logic              indHit;

  burst_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .ceN     (ceN),
    .advN    (advN),
    .latCode (latCode),
    .strobes (strobes)
  );

  burst_datapath #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W),
    .WRAP_W(WRAP_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .addrIn    (addr),
    .indEarly  (indEarly),
    .wordValid (wordValid),
    .wordData  (wordData),
    .indHit    (indHit)
  );

  assign dataValid = wordValid && !ceN && !oeN;
  assign dataOut   = dataValid ? wordData : '0;
  assign indN      = !(indHit && !ceN);

  // R9: chip enable high at an edge empties the read path
  p_abort_clears_r9: assert property (@(posedge clk) disable iff (!rstN)
    ceN |=> !wordValid);

  // R10: a start edge drops any word of the previous burst
  p_restart_flush_r10: assert property (@(posedge clk) disable iff (!rstN)
    strobes.loadAddr |=> !wordValid);

endmodule

// File: tb/burst_read_seq_bench.sv
`timescale 1ns/1ps
module burst_read_seq_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        ceN = 1'b1;
  logic        oeN = 1'b1;
  logic        advN = 1'b1;
  logic [7:0]  addr = '0;
  logic [3:0]  latCode = 4'd1;
  logic        indEarly = 1'b0;
  logic [31:0] dataOut;
  logic        dataValid;
  logic        indN;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  burst_read_seq u_burst_read_seq (
    .clk(clk), .rstN(rstN), .ceN(ceN), .oeN(oeN), .advN(advN),
    .addr(addr), .latCode(latCode), .indEarly(indEarly),
    .dataOut(dataOut), .dataValid(dataValid), .indN(indN)
  );

  function automatic int latOf(input int code);
    return (code >= 1 && code <= 7) ? code + 2 : 3;
  endfunction

  function automatic logic [31:0] wordAt(input logic [7:0] a);
    return ({24'h0, a} * 32'h01010101) ^ 32'hC35AC35A;
  endfunction

  task automatic chk(input string tag, input bit expValid,
                     input logic [31:0] expData, input bit expIndN);
    checks++;
    if (dataValid !== expValid || dataOut !== expData || indN !== expIndN) begin
      errors++;
      $display("FAIL %s: got valid=%0b data=%h indN=%0b, expected valid=%0b data=%h indN=%0b",
               tag, dataValid, dataOut, indN, expValid, expData, expIndN);
    end
  endtask

  // caller is just past a falling edge; leaves the block idle
  task automatic goIdle();
    ceN = 1'b1; oeN = 1'b1; advN = 1'b1;
    @(negedge clk);
    chk("R9 idle", 1'b0, 32'h0, 1'b1);
    @(negedge clk);
  endtask

  // caller is just past a falling edge; j counts rising edges after the start edge
  task automatic runBurst(input int code, input int sel, input int a, input bit holdAdv,
                          input int oeFrom, input int ceFrom, input int lastJ,
                          input string tag);
    int L;
    int target;
    L = latOf(code);
    target = (sel != 0) ? 2 : 3;
    ceN = 1'b0; oeN = 1'b0; advN = 1'b0;
    addr = 8'(a); latCode = 4'(code); indEarly = (sel != 0);
    @(negedge clk);
    for (int j = 0; j <= lastJ; j++) begin
      bit aborted;
      bit oeOff;
      bit streaming;
      bit expValid;
      bit expIndLow;
      logic [7:0] wAddr;
      if (j > 0) @(negedge clk);
      aborted   = (ceFrom >= 0) && (j > ceFrom);
      oeOff     = (oeFrom >= 0) && (j > oeFrom) && (j <= oeFrom + 2);
      streaming = (j >= L) && !aborted;
      wAddr     = {8'(a) & 8'hFC} | 8'((a + (j - L)) & 3);
      expValid  = streaming && !oeOff;
      expIndLow = streaming && (int'(wAddr[1:0]) == target);
      chk(tag, expValid, expValid ? wordAt(wAddr) : 32'h0, !expIndLow);
      if (!holdAdv) advN = 1'b1;
      addr = 8'(a) ^ 8'h5A;
      if (j == oeFrom) oeN = 1'b1;
      if (j == oeFrom + 2) oeN = 1'b0;
      if (j == ceFrom) ceN = 1'b1;
      if (j == ceFrom + 2) ceN = 1'b0;
    end
  endtask

  initial begin
    #1_500_000;
    errors++;
    $display("FAIL watchdog: got hung run, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // R1: reset state with enables active
    ceN = 1'b0; oeN = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 in reset", 1'b0, 32'h0, 1'b1);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 after reset", 1'b0, 32'h0, 1'b1);
    goIdle();

    // R3 R4 R5 R6 R7: every code, both indicator positions, all offsets
    for (int code = 0; code < 16; code++) begin
      for (int sel = 0; sel < 2; sel++) begin
        for (int off = 0; off < 4; off++) begin
          int a;
          a = (((code * 37 + sel * 91) << 2) & 8'hFC) | off;
          runBurst(code, sel, a, 1'b0, -1, -1, latOf(code) + 7,
                   (code >= 1 && code <= 7) ? "R3 R5 R6 R7 sweep" : "R4 R5 R6 R7 sweep");
          goIdle();
        end
      end
    end

    // R2: strobe held low for the whole burst does not restart it
    runBurst(4, 0, 8'h31, 1'b1, -1, -1, 14, "R2 held strobe");
    goIdle();

    // R2: strobe already low when chip enable falls starts nothing
    ceN = 1'b1; advN = 1'b0; addr = 8'h44; latCode = 4'd1;
    @(negedge clk);
    ceN = 1'b0; oeN = 1'b0;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      chk("R2 no edge", 1'b0, 32'h0, 1'b1);
    end
    goIdle();

    // R8: output enable gap in the data phase
    runBurst(3, 0, 8'h92, 1'b0, 6, -1, 14, "R8 oe gap");
    goIdle();
    runBurst(1, 1, 8'h17, 1'b0, 4, -1, 12, "R8 oe gap early ind");
    goIdle();

    // R9: abort in the data phase, then no data without a new strobe
    runBurst(2, 0, 8'hA1, 1'b0, -1, 5, 16, "R9 abort");
    goIdle();
    // R9: abort during the wait phase
    runBurst(7, 1, 8'h6C, 1'b0, -1, 2, 16, "R9 abort in wait");
    goIdle();

    // R10: restart during the data phase
    runBurst(2, 0, 8'h21, 1'b0, -1, -1, 6, "R10 first burst");
    runBurst(5, 1, 8'hCE, 1'b0, -1, -1, 14, "R10 restarted burst");
    goIdle();
    // R10: restart during the wait phase
    runBurst(6, 0, 8'h10, 1'b0, -1, -1, 2, "R10 first burst wait");
    runBurst(1, 0, 8'h7B, 1'b0, -1, -1, 11, "R10 restarted from wait");
    goIdle();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule